// File: doc/BRIEF.md
# Packed Saturating Add/Subtract Unit

This block adds or subtracts two 64-bit operands lane by lane. Eight 8-bit lanes, four 16-bit lanes or two 32-bit lanes are processed independently. Each lane result is written back to the bit positions its operands came from. An 8-bit operation code sets the lane size, the direction (add or subtract) and what happens on overflow. The overflow choices are to wrap modulo the lane size, to clamp to the signed range, or to clamp to the unsigned range. Only the 8-bit and 16-bit lane sizes can clamp. The unit sees just this one code byte; fetch, operand addressing and condition flags are handled elsewhere.

A valid strobe captures the operation. The result and an illegal-code flag appear on registered outputs one clock later, together with an output valid pulse. Any code outside the supported set raises the illegal flag and produces an all-zero result. This includes the clamping codes at the 32-bit lane size, which do not exist.

Top module: `addsub_unit`

## Requirements
- R1: Codes 0xFC, 0xFD and 0xFE add with wrap-around on 8-, 16- and 32-bit lanes respectively. Each lane result is (a + b) mod 2^width.
- R2: Codes 0xF8, 0xF9 and 0xFA subtract with wrap-around on 8-, 16- and 32-bit lanes. Each lane result is (a - b) mod 2^width, with the first operand as the minuend.
- R3: Codes 0xEC (8-bit) and 0xED (16-bit) add as two's-complement numbers. A sum above the lane maximum gives 0x7F / 0x7FFF, and a sum below the lane minimum gives 0x80 / 0x8000.
- R4: Codes 0xE8 (8-bit) and 0xE9 (16-bit) compute a - b as two's-complement numbers, clamped to the same signed lane limits as R3.
- R5: Codes 0xDC (8-bit) and 0xDD (16-bit) add as unsigned numbers. A sum above the lane range gives all ones in that lane.
- R6: Codes 0xD8 (8-bit) and 0xD9 (16-bit) compute a - b as unsigned numbers. A lane whose difference would be negative gives zero.
- R7: No carry or borrow passes between lanes: a lane's result depends only on the same lane of both operands.
- R8: Every other code raises the illegal flag with an all-zero result. This includes the would-be 32-bit clamping codes 0xEE, 0xEA, 0xDE and 0xDA. A supported code clears the flag.
- R9: When in_valid is high at a rising edge, result and illegal update at that edge and out_valid is high for the following cycle. When in_valid is low, result and illegal hold and out_valid is low.
- R10: While reset is asserted, out_valid, illegal and result are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Capture strobe for the operation |
| opcode | input | 8 | Operation code byte |
| src_a | input | 64 | First operand (minuend) |
| src_b | input | 64 | Second operand (subtrahend) |
| out_valid | output | 1 | High one cycle after a captured operation |
| result | output | 64 | Registered packed result |
| illegal | output | 1 | Registered unsupported-code flag |

## Verification
The assertions check several properties on every cycle and in every lane. An unsigned clamped sum never falls below its first operand, and an unsigned clamped difference never exceeds it. A signed clamped result keeps the sign of its first operand whenever overflow is possible. The 32-bit clamping codes never decode as legal. The output valid and hold timing follows the strobe. Exact lane values cannot be shown by these properties: that clamping picks precisely 0x7F versus 0x80, that lanes stay isolated, and that the three lane sizes are selected correctly. Only the bench's directed corner operands and its comparison against a reference model of seeded random operations show these.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

  typedef enum logic [1:0] {
    LW_8  = 2'd0,
    LW_16 = 2'd1,
    LW_32 = 2'd2
  } lane_sel_e;

  typedef enum logic [1:0] {
    OVF_WRAP = 2'd0,
    OVF_SSAT = 2'd1,
    OVF_USAT = 2'd2
  } ovf_mode_e;

  typedef struct packed {
    logic      legal;
    logic      sub;
    lane_sel_e lane;
    ovf_mode_e mode;
  } op_ctl_t;

endpackage

// File: rtl/addsub_decode.sv
module addsub_decode
  import addsub_pkg::*;
(
  input  logic [7:0] opcode,
  output op_ctl_t    ctl
);

  always_comb begin
    ctl = '{legal: 1'b1, sub: 1'b0, lane: LW_8, mode: OVF_WRAP};
    unique case (opcode)
      8'hFC: ctl = '{1'b1, 1'b0, LW_8,  OVF_WRAP};
      8'hFD: ctl = '{1'b1, 1'b0, LW_16, OVF_WRAP};
      8'hFE: ctl = '{1'b1, 1'b0, LW_32, OVF_WRAP};
      8'hF8: ctl = '{1'b1, 1'b1, LW_8,  OVF_WRAP};
      8'hF9: ctl = '{1'b1, 1'b1, LW_16, OVF_WRAP};
      8'hFA: ctl = '{1'b1, 1'b1, LW_32, OVF_WRAP};
      8'hEC: ctl = '{1'b1, 1'b0, LW_8,  OVF_SSAT};
      8'hED: ctl = '{1'b1, 1'b0, LW_16, OVF_SSAT};
      8'hE8: ctl = '{1'b1, 1'b1, LW_8,  OVF_SSAT};
      8'hE9: ctl = '{1'b1, 1'b1, LW_16, OVF_SSAT};
      8'hDC: ctl = '{1'b1, 1'b0, LW_8,  OVF_USAT};
      8'hDD: ctl = '{1'b1, 1'b0, LW_16, OVF_USAT};
      8'hD8: ctl = '{1'b1, 1'b1, LW_8,  OVF_USAT};
      8'hD9: ctl = '{1'b1, 1'b1, LW_16, OVF_USAT};
      default: ctl = '{1'b0, 1'b0, LW_8, OVF_WRAP};
    endcase
  end

  // R8: clamping codes at 32-bit lane size never decode as legal
  always_comb begin
    if (opcode == 8'hEE || opcode == 8'hEA || opcode == 8'hDE || opcode == 8'hDA)
      p_no_dword_sat_r8: assert (!ctl.legal)
        else $error("32-bit clamping code decoded as legal");
  end

  // R8: a legal code with clamping never selects the 32-bit lane size
  always_comb begin
    if (ctl.legal && ctl.mode != OVF_WRAP)
      p_sat_lane_r8: assert (ctl.lane != LW_32)
        else $error("clamping selected on 32-bit lanes");
  end

endmodule

// File: rtl/addsub_lane.sv
module addsub_lane
  import addsub_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  ovf_mode_e    mode,
  output logic [W-1:0] y
);

  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] b_eff;
  logic [W:0]   sum;
  logic [W-1:0] raw;
  logic         carry;
  logic         s_ovf;
  logic         u_ovf;

  always_comb begin
    b_eff = sub ? ~b : b;
    sum   = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
    raw   = sum[W-1:0];
    carry = sum[W];
    s_ovf = (a[W-1] == b_eff[W-1]) && (raw[W-1] != a[W-1]);
    u_ovf = sub ? ~carry : carry;
  end

  always_comb begin
    y = raw;
    unique case (mode)
      OVF_SSAT: if (s_ovf) y = a[W-1] ? SMIN : SMAX;
      OVF_USAT: if (u_ovf) y = sub ? '0 : '1;
      default:  y = raw;
    endcase
  end

  // R5: unsigned clamped sum never below the first operand
  always_comb begin
    if (mode == OVF_USAT && !sub)
      p_usat_add_r5: assert (y >= a) else $error("unsigned clamp add below operand");
  end

  // R6: unsigned clamped difference never above the first operand
  always_comb begin
    if (mode == OVF_USAT && sub)
      p_usat_sub_r6: assert (y <= a) else $error("unsigned clamp sub above operand");
  end

  // R3, R4: where overflow is possible the clamped result keeps a's sign
  always_comb begin
    if (mode == OVF_SSAT && (a[W-1] == b_eff[W-1]))
      p_ssat_sign_r3: assert (y[W-1] == a[W-1]) else $error("signed clamp sign flip");
  end

endmodule

// File: rtl/addsub_bank.sv
module addsub_bank
  import addsub_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              sub,
  input  ovf_mode_e         mode,
  output logic [DATA_W-1:0] y
);

  localparam int NLANES = DATA_W / LANE_W;

  for (genvar i = 0; i < NLANES; i++) begin : g_lane
    addsub_lane #(.W(LANE_W)) u_lane (
      .a   (a[i*LANE_W +: LANE_W]),
      .b   (b[i*LANE_W +: LANE_W]),
      .sub (sub),
      .mode(mode),
      .y   (y[i*LANE_W +: LANE_W])
    );
  end

endmodule

// File: rtl/addsub_unit.sv
module addsub_unit
  import addsub_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        opcode,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              illegal
);

  localparam int W8  = 8;
  localparam int W16 = 2 * W8;
  localparam int W32 = 2 * W16;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  op_ctl_t ctl;
  logic [DATA_W-1:0] y8, y16, y32;
  logic [DATA_W-1:0] res_d, res_q;
  logic              ill_d, ill_q, vld_q;

  addsub_decode u_decode (.opcode(opcode), .ctl(ctl));

  addsub_bank #(.DATA_W(DATA_W), .LANE_W(W8)) u_bank8 (
    .a(src_a), .b(src_b), .sub(ctl.sub), .mode(ctl.mode), .y(y8));
  addsub_bank #(.DATA_W(DATA_W), .LANE_W(W16)) u_bank16 (
    .a(src_a), .b(src_b), .sub(ctl.sub), .mode(ctl.mode), .y(y16));
  addsub_bank #(.DATA_W(DATA_W), .LANE_W(W32)) u_bank32 (
    .a(src_a), .b(src_b), .sub(ctl.sub), .mode(ctl.mode), .y(y32));

  // next state
  always_comb begin
    unique case (ctl.lane)
      LW_16:   res_d = y16;
      LW_32:   res_d = y32;
      default: res_d = y8;
    endcase
    if (!ctl.legal) res_d = '0;
    ill_d = ~ctl.legal;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      ill_q <= 1'b0;
      vld_q <= 1'b0;
    end else if (!rst_n_s) begin
      res_q <= '0;
      ill_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= in_valid;
      if (in_valid) begin
        res_q <= res_d;
        ill_q <= ill_d;
      end
    end
  end

  assign out_valid = vld_q;
  assign result    = res_q;
  assign illegal   = ill_q;

  // R9: strobe gives an output valid pulse next cycle
  p_valid_follow_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    in_valid |=> out_valid);

  // R9: no strobe, no pulse, outputs hold
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    !in_valid |=> (!out_valid && $stable(result) && $stable(illegal)));

  // R8: illegal flag always comes with an all-zero result
  p_illegal_zero_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    illegal |-> (result == '0));

endmodule

// File: tb/addsub_unit_tb.sv
module addsub_unit_tb;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [7:0]  opcode;
  logic [63:0] src_a, src_b;
  logic        out_valid;
  logic [63:0] result;
  logic        illegal;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  addsub_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
    .src_a(src_a), .src_b(src_b), .out_valid(out_valid),
    .result(result), .illegal(illegal)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // reference: {illegal, result}
  function automatic logic [64:0] model(input logic [7:0] op,
                                        input logic [63:0] a, input logic [63:0] b);
    int lw = 8;
    int md = 0;
    bit sb = 0;
    bit ok = 1;
    logic [63:0] res = '0;
    case (op)
      8'hFC: begin lw = 8;  md = 0; sb = 0; end
      8'hFD: begin lw = 16; md = 0; sb = 0; end
      8'hFE: begin lw = 32; md = 0; sb = 0; end
      8'hF8: begin lw = 8;  md = 0; sb = 1; end
      8'hF9: begin lw = 16; md = 0; sb = 1; end
      8'hFA: begin lw = 32; md = 0; sb = 1; end
      8'hEC: begin lw = 8;  md = 1; sb = 0; end
      8'hED: begin lw = 16; md = 1; sb = 0; end
      8'hE8: begin lw = 8;  md = 1; sb = 1; end
      8'hE9: begin lw = 16; md = 1; sb = 1; end
      8'hDC: begin lw = 8;  md = 2; sb = 0; end
      8'hDD: begin lw = 16; md = 2; sb = 0; end
      8'hD8: begin lw = 8;  md = 2; sb = 1; end
      8'hD9: begin lw = 16; md = 2; sb = 1; end
      default: ok = 0;
    endcase
    if (!ok) return {1'b1, 64'd0};
    for (int i = 0; i < 64 / lw; i++) begin
      longint mask = (longint'(1) << lw) - 1;
      longint ua = longint'(a >> (i * lw)) & mask;
      longint ub = longint'(b >> (i * lw)) & mask;
      longint half = longint'(1) << (lw - 1);
      longint sa = (ua >= half) ? ua - (mask + 1) : ua;
      longint sbv = (ub >= half) ? ub - (mask + 1) : ub;
      longint r;
      if (md == 1) begin
        r = sb ? sa - sbv : sa + sbv;
        if (r > half - 1) r = half - 1;
        if (r < -half)    r = -half;
      end else begin
        r = sb ? ua - ub : ua + ub;
        if (md == 2) begin
          if (r > mask) r = mask;
          if (r < 0)    r = 0;
        end
      end
      res = res | (64'(r & mask) << (i * lw));
    end
    return {1'b0, res};
  endfunction

  function automatic string req_of(input logic [7:0] op);
    case (op)
      8'hFC, 8'hFD, 8'hFE: return "R1";
      8'hF8, 8'hF9, 8'hFA: return "R2";
      8'hEC, 8'hED:        return "R3";
      8'hE8, 8'hE9:        return "R4";
      8'hDC, 8'hDD:        return "R5";
      8'hD8, 8'hD9:        return "R6";
      default:             return "R8";
    endcase
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, captured at posedge, sampled at following negedge
  task automatic apply(input string req, input logic [7:0] op,
                       input logic [63:0] a, input logic [63:0] b);
    logic [64:0] e;
    e = model(op, a, b);
    @(negedge clk);
    in_valid = 1'b1; opcode = op; src_a = a; src_b = b;
    @(negedge clk);
    chk(req, result, e[63:0]);
    chk(req, {63'd0, illegal}, {63'd0, e[64]});
    chk("R9", {63'd0, out_valid}, 64'd1);
    in_valid = 1'b0;
  endtask

  logic [7:0] legal_ops [14] = '{8'hFC, 8'hFD, 8'hFE, 8'hF8, 8'hF9, 8'hFA, 8'hEC,
                                 8'hED, 8'hE8, 8'hE9, 8'hDC, 8'hDD, 8'hD8, 8'hD9};

  initial begin
    logic [63:0] held;
    rst_n = 1'b0; in_valid = 1'b0; opcode = '0; src_a = '0; src_b = '0;
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10", {62'd0, out_valid, illegal}, 64'd0);
    chk("R10", result, 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // directed corners
    apply("R1", 8'hFC, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101);
    apply("R1", 8'hFD, 64'h7FFF_FFFF_0001_8000, 64'h0001_0001_FFFF_8000);
    apply("R7", 8'hFE, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001);
    apply("R7", 8'hFC, 64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001);
    apply("R2", 8'hF8, 64'h0000_0000_0000_0000, 64'h0102_0304_0506_0708);
    apply("R2", 8'hFA, 64'h0000_0001_0000_0000, 64'h0000_0000_0000_0001);
    apply("R3", 8'hEC, 64'h7F80_7F80_0102_FF00, 64'h01FF_7F80_0203_FF00);
    apply("R3", 8'hED, 64'h7FFF_8000_1234_FFFF, 64'h0001_FFFF_0001_0001);
    apply("R4", 8'hE8, 64'h8080_7F7F_0505_0000, 64'h0101_FFFF_0A0A_0000);
    apply("R4", 8'hE9, 64'h8000_7FFF_0000_0003, 64'h0001_FFFF_8000_0001);
    apply("R5", 8'hDC, 64'hF0F0_0102_FFFF_8080, 64'h2020_0304_0001_8080);
    apply("R5", 8'hDD, 64'hFFFF_8000_0001_0000, 64'h0001_8000_0002_0000);
    apply("R6", 8'hD8, 64'h0102_FFFF_0000_1010, 64'h0203_0001_0001_1010);
    apply("R6", 8'hD9, 64'h0001_FFFF_8000_0000, 64'h0002_0001_8001_0000);
    apply("R8", 8'hEE, 64'h7FFF_FFFF_7FFF_FFFF, 64'h0000_0001_0000_0001);
    apply("R8", 8'hEA, 64'h1234_5678_9ABC_DEF0, 64'h1111_1111_1111_1111);
    apply("R8", 8'hDE, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1111_1111_1111_1111);
    apply("R8", 8'hDA, 64'h1234_5678_9ABC_DEF0, 64'h1111_1111_1111_1111);
    apply("R8", 8'h00, 64'h1234_5678_9ABC_DEF0, 64'h1111_1111_1111_1111);
    apply("R8", 8'hFC, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0001);

    // R9: without strobe the outputs hold and valid stays low
    held = result;
    @(negedge clk);
    opcode = 8'hFD; src_a = 64'hAAAA_AAAA_AAAA_AAAA; src_b = 64'h5555_5555_5555_5555;
    @(negedge clk);
    chk("R9", result, held);
    chk("R9", {62'd0, out_valid, illegal}, 64'd0);

    // seeded random operations
    for (int n = 0; n < 1500; n++) begin
      logic [7:0]  op;
      logic [63:0] a, b;
      if (($urandom % 8) == 0) op = 8'($urandom);
      else                     op = legal_ops[$urandom % 14];
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      if (($urandom % 4) == 0) b = a ^ {$urandom, $urandom} & 64'h8080_8080_8080_8080;
      apply(req_of(op), op, a, b);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule